// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Condition Flags

This block computes one byte-wide arithmetic, logic, rotate or decimal-adjust operation per clock and produces the condition flags that the operation defines. These flags are carry (C), nibble carry (AC), zero (Z) and signed overflow (OV). It takes two operands, a 4-bit operation code, the current carry flag and the current nibble-carry flag. It returns the result, the new flag values and one enable per flag. Each enable tells the surrounding datapath whether its flag register should take the new value.

Inputs are captured combinationally and every output is registered, so a result appears one clock after its operands. The flag registers, the destination writeback and any branch sequencing live outside this block. Subtraction follows the "carry means no borrow" convention, and OV is the exclusive-OR of the carry into and out of the top bit.

Top module: `alu8_flag_unit`

## Requirements
- R1: A synchronous active-high `rst` clears every output to zero on the next rising edge. Outside reset, outputs reflect the inputs sampled at the previous rising edge.
- R2: Code 0 (add) returns A+B, and code 1 (add with carry) returns A+B+c_in, both mod 256. C is the carry out of bit 7. AC is the carry out of bit 3. OV is set when the signed sum leaves -128..127. All four flags are enabled.
- R3: Code 2 (subtract) returns A-B, and code 3 (subtract with borrow) returns A-B-(1-c_in), both mod 256. C is 1 when the true difference is not negative. AC is 1 when the low-nibble difference is not negative. OV is set when the signed difference leaves -128..127. All four flags are enabled.
- R4: Whenever upd_z is 1, z_out is 1 exactly when the 8-bit result is zero.
- R5: Codes 5, 6 and 7 return A AND B, A OR B and A XOR B. Code 8 returns NOT A. These codes enable Z only.
- R6: Code 13 returns A+1 and code 14 returns A-1, both wrapping mod 256. These codes enable Z only.
- R7: Code 9 rotates A left by one bit and code 10 rotates A right by one bit, both within the byte. No flag is enabled.
- R8: Code 11 rotates left through carry, giving {A[6:0],c_in} with C=A[7]. Code 12 rotates right through carry, giving {c_in,A[7:1]} with C=A[0]. Only C is enabled.
- R9: Code 4 (decimal adjust) first forms T=A+6 when A[3:0]>9 or ac_in is 1, and T=A otherwise, as a 9-bit value. If c_in is 1, T[8] is 1 or T[7:4]>9, it then adds 60h to T[7:0] and sets C. Otherwise C is 0. Only C is enabled.
- R10: Code 15 passes A through unchanged and enables no flag.
- R11: A flag value output whose enable is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation select, codes per R2 to R10 |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| c_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current nibble-carry flag |
| result | output | 8 | Registered result |
| c_out | output | 1 | New carry value |
| ac_out | output | 1 | New nibble-carry value |
| z_out | output | 1 | New zero value |
| ov_out | output | 1 | New overflow value |
| upd_c | output | 1 | C update enable |
| upd_ac | output | 1 | AC update enable |
| upd_z | output | 1 | Z update enable |
| upd_ov | output | 1 | OV update enable |

## Verification
The only state is the output register, so any fault in the shared adder, in the carry-in selection, in the decimal-adjust stages or in the enable decode appears at the ports. It shows up in the very next cycle for the operand pair that exercises it. A wrong operand inversion or carry-in choice for subtract shows first as a wrong C for equal operands or for operands one apart. A wrong nibble-boundary tap shows as a wrong AC or as a missed decimal-adjust correction. A swapped enable shows as a flag that is nonzero while its enable is low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_DAJ  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_NOT  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_ROLC = 4'd11,
    OP_RORC = 4'd12,
    OP_INC  = 4'd13,
    OP_DEC  = 4'd14,
    OP_PASS = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic ac;
    logic z;
    logic ov;
  } flag_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              nib_cout,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [NIB_W:0] nib_sum;
  logic [MSB:0]   low_sum;
  logic [1:0]     top_sum;

  // carry out of the low nibble
  assign nib_sum = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, cin};
  // bits below the MSB, exposing the carry into the MSB
  assign low_sum = {1'b0, a[MSB-1:0]} + {1'b0, b[MSB-1:0]}
                 + {{(DATA_W-1){1'b0}}, cin};
  assign top_sum = {1'b0, a[MSB]} + {1'b0, b[MSB]} + {1'b0, low_sum[MSB]};

  assign sum      = {top_sum[0], low_sum[MSB-1:0]};
  assign cout     = top_sum[1];
  assign nib_cout = nib_sum[NIB_W];
  assign ovf      = top_sum[1] ^ low_sum[MSB];
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  input  logic              to_right,
  input  logic              via_carry,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int MSB = DATA_W - 1;

  logic fill_l, fill_r;

  assign fill_l = via_carry ? cin : a[MSB];
  assign fill_r = via_carry ? cin : a[0];

  always_comb begin
    if (to_right) begin
      res  = {fill_r, a[MSB:1]};
      cout = a[0];
    end else begin
      res  = {a[MSB-1:0], fill_l};
      cout = a[MSB];
    end
  end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  input  logic              acin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int          MSB     = DATA_W - 1;
  localparam int          DIG_MAX = 9;
  localparam int          FIX     = 6;
  localparam [DATA_W:0]   LO_FIX  = DATA_W'(FIX);
  localparam [DATA_W-1:0] HI_FIX  = DATA_W'(FIX << NIB_W);

  logic            lo_need, hi_need;
  logic [DATA_W:0] stage1;

  assign lo_need = (int'(a[NIB_W-1:0]) > DIG_MAX) || acin;
  assign stage1  = {1'b0, a} + (lo_need ? LO_FIX : '0);
  assign hi_need = cin || stage1[DATA_W] ||
                   (int'(stage1[MSB:NIB_W]) > DIG_MAX);
  assign res     = stage1[MSB:0] + (hi_need ? HI_FIX : '0);
  assign cout    = hi_need;
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              c_in,
  input  logic              ac_in,
  output logic [DATA_W-1:0] result,
  output logic              c_out,
  output logic              ac_out,
  output logic              z_out,
  output logic              ov_out,
  output logic              upd_c,
  output logic              upd_ac,
  output logic              upd_z,
  output logic              upd_ov
);
  import alu8_pkg::*;

  localparam int MSB = DATA_W - 1;

  alu_op_e         op;
  logic [MSB:0]    add_b, add_sum, rot_res, daj_res, res_n;
  logic            add_cin, add_c, add_ac, add_ov;
  logic            rot_c, daj_c, rot_right, rot_thru;
  flag_t           val_n, en_n;

  assign op = alu_op_e'(op_code);

  // operand shaping for the shared adder
  always_comb begin
    add_b   = op_b;
    add_cin = 1'b0;
    unique case (op)
      OP_ADC:  add_cin = c_in;
      OP_SUB:  begin add_b = ~op_b; add_cin = 1'b1; end
      OP_SBC:  begin add_b = ~op_b; add_cin = c_in; end
      OP_INC:  begin add_b = '0;    add_cin = 1'b1; end
      OP_DEC:  add_b = '1;
      default: ;
    endcase
  end

  alu8_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_add (
    .a(op_a), .b(add_b), .cin(add_cin),
    .sum(add_sum), .cout(add_c), .nib_cout(add_ac), .ovf(add_ov)
  );

  assign rot_right = (op == OP_ROR) || (op == OP_RORC);
  assign rot_thru  = (op == OP_ROLC) || (op == OP_RORC);

  alu8_rotate #(.DATA_W(DATA_W)) u_rot (
    .a(op_a), .cin(c_in), .to_right(rot_right), .via_carry(rot_thru),
    .res(rot_res), .cout(rot_c)
  );

  alu8_decadj #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_daj (
    .a(op_a), .cin(c_in), .acin(ac_in), .res(daj_res), .cout(daj_c)
  );

  // result select and flag enables
  always_comb begin
    res_n = op_a;
    en_n  = '0;
    val_n = '0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_n = add_sum;
        en_n  = '{c: 1'b1, ac: 1'b1, z: 1'b1, ov: 1'b1};
        val_n.c  = add_c;
        val_n.ac = add_ac;
        val_n.ov = add_ov;
      end
      OP_INC, OP_DEC: begin res_n = add_sum;     en_n.z = 1'b1; end
      OP_AND:         begin res_n = op_a & op_b; en_n.z = 1'b1; end
      OP_OR:          begin res_n = op_a | op_b; en_n.z = 1'b1; end
      OP_XOR:         begin res_n = op_a ^ op_b; en_n.z = 1'b1; end
      OP_NOT:         begin res_n = ~op_a;       en_n.z = 1'b1; end
      OP_ROL, OP_ROR: res_n = rot_res;
      OP_ROLC, OP_RORC: begin
        res_n   = rot_res;
        en_n.c  = 1'b1;
        val_n.c = rot_c;
      end
      OP_DAJ: begin
        res_n   = daj_res;
        en_n.c  = 1'b1;
        val_n.c = daj_c;
      end
      default: ;
    endcase
    val_n.z = en_n.z && (res_n == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      {c_out, ac_out, z_out, ov_out} <= '0;
      {upd_c, upd_ac, upd_z, upd_ov} <= '0;
    end else begin
      result <= res_n;
      {c_out, ac_out, z_out, ov_out} <= val_n;
      {upd_c, upd_ac, upd_z, upd_ov} <= en_n;
    end
  end

  // ---------------- assertions ----------------
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result == '0 && !upd_c && !upd_ac && !upd_z && !upd_ov));

  assert_sub_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd2) |=> (c_out == ($past(op_a) >= $past(op_b))));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
    upd_z |-> (z_out == (result == '0)));

  assert_rotate_plain_R7: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd9) |=>
      (result == {$past(op_a[MSB-1:0]), $past(op_a[MSB])}) &&
      !upd_c && !upd_ac && !upd_z && !upd_ov);

  assert_pass_no_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd15) |=> (result == $past(op_a)) &&
      $countones({upd_c, upd_ac, upd_z, upd_ov}) == 0);

  assert_masked_flags_R11: assert property (@(posedge clk) disable iff (rst)
    ({c_out, ac_out, z_out, ov_out} & ~{upd_c, upd_ac, upd_z, upd_ov}) == 4'b0);
endmodule

// File: tb/alu8_flag_unit_tb.sv
module alu8_flag_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] op_code;
  logic [7:0] op_a, op_b, result;
  logic       c_in, ac_in;
  logic       c_out, ac_out, z_out, ov_out;
  logic       upd_c, upd_ac, upd_z, upd_ov;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flag_unit u_dut (
    .clk(clk), .rst(rst), .op_code(op_code), .op_a(op_a), .op_b(op_b),
    .c_in(c_in), .ac_in(ac_in), .result(result),
    .c_out(c_out), .ac_out(ac_out), .z_out(z_out), .ov_out(ov_out),
    .upd_c(upd_c), .upd_ac(upd_ac), .upd_z(upd_z), .upd_ov(upd_ov)
  );

  // expected: {res[7:0], en c,ac,z,ov, val c,ac,z,ov}
  function automatic logic [15:0] model(int op, int a, int b, int c, int ac);
    int r = a;
    int en = 0;
    int fc = 0, fac = 0, fov = 0;
    int sa = (a > 127) ? a - 256 : a;
    int sb = (b > 127) ? b - 256 : b;
    case (op)
      0, 1: begin
        int ci = (op == 1) ? c : 0;
        int s = a + b + ci;
        int ss = sa + sb + ci;
        r = s % 256; en = 4'hF;
        fc = (s > 255); fac = ((a % 16) + (b % 16) + ci) > 15;
        fov = (ss > 127) || (ss < -128);
      end
      2, 3: begin
        int bi = (op == 3) ? 1 - c : 0;
        int d = a - b - bi;
        int sd = sa - sb - bi;
        r = (d + 512) % 256; en = 4'hF;
        fc = (d >= 0); fac = ((a % 16) - (b % 16) - bi) >= 0;
        fov = (sd > 127) || (sd < -128);
      end
      4: begin
        int t = a + ((((a % 16) > 9) || ac == 1) ? 6 : 0);
        int h = (c == 1) || (t > 255) || (((t / 16) % 16) > 9);
        r = (t + (h ? 96 : 0)) % 256; en = 4'h8; fc = h;
      end
      5:  begin r = a & b;  en = 4'h2; end
      6:  begin r = a | b;  en = 4'h2; end
      7:  begin r = a ^ b;  en = 4'h2; end
      8:  begin r = 255 - a; en = 4'h2; end
      9:  r = ((a * 2) % 256) + (a / 128);
      10: r = (a / 2) + (a % 2) * 128;
      11: begin r = ((a * 2) % 256) + c; en = 4'h8; fc = a / 128; end
      12: begin r = (a / 2) + c * 128;   en = 4'h8; fc = a % 2;   end
      13: begin r = (a + 1) % 256;       en = 4'h2; end
      14: begin r = (a + 255) % 256;     en = 4'h2; end
      default: ;
    endcase
    return {8'(r), 4'(en), 1'(fc), 1'(fac), 1'(((en & 2) != 0) && r == 0), 1'(fov)};
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4:       return "R9";
      5,6,7,8: return "R5";
      9, 10:   return "R7";
      11, 12:  return "R8";
      13, 14:  return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] observed();
    return {result, upd_c, upd_ac, upd_z, upd_ov, c_out, ac_out, z_out, ov_out};
  endfunction

  task automatic check_vector(int op, logic [15:0] exp);
    logic [15:0] act = observed();
    check(tag_of(op), act, exp);
    // R4: zero flag tracks the result whenever enabled
    check("R4", {15'd0, act[1]}, {15'd0, act[5] && act[15:8] == 8'd0});
    // R11: masked flag values read zero
    check("R11", {12'd0, act[3:0] & ~act[7:4]}, 16'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] exp_prev = '0;
    int op_prev = 0;
    bit have_prev = 1'b0;
    rst = 1'b1; op_code = 4'd0; op_a = 8'hA5; op_b = 8'h5A; c_in = 1'b1; ac_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", observed(), 16'd0);
    rst = 1'b0;

    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 9; bi++)
          for (int c = 0; c < 2; c++) begin
            int b = (bi == 0) ? 0 : bi * 32 - 1;
            @(negedge clk);
            if (have_prev) check_vector(op_prev, exp_prev);
            op_code = 4'(op); op_a = 8'(a); op_b = 8'(b);
            c_in = 1'(c); ac_in = 1'(bi % 2);
            exp_prev = model(op, a, b, c, bi % 2);
            op_prev = op; have_prev = 1'b1;
          end
    @(negedge clk);
    check_vector(op_prev, exp_prev);

    // R1: mid-run reset overrides a live operation
    op_code = 4'd0; op_a = 8'hFF; op_b = 8'h01; rst = 1'b1;
    @(negedge clk);
    check("R1", observed(), 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", observed(), model(0, 255, 1, 0, 0));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule